// File: doc/BRIEF.md
# Mixed-Sign Integer Multiply Unit

This execution unit forms the full 32-bit integer product of a signed 16-bit operand and an unsigned 16-bit operand. Extended-precision multiplication, such as a 32×32 product built from 16-bit pieces, uses it for the cross term that pairs a signed upper word with an unsigned lower word. The first operand is always the upper word of one accumulator. The second is always the lower word of one accumulator. A 3-bit pairing code picks one of eight legal combinations.

The product is registered into a fixed 32-bit Y destination, and a write strobe marks the cycle it lands. The unit never saturates or limits the result and keeps no flags. It only reads the accumulator words and never drives them back.

Top module: `mixmul_unit`

## Requirements
- R1: On issue, Y becomes the low 32 bits of (first operand read as two's-complement) × (second operand read as unsigned 0..65535). Y1 is y_o[31:16] and Y0 is y_o[15:0]. For example, 0xFFFE × 0x0002 gives 0xFFFF_FFFC, and 0x8000 × 0xFFFF gives 0x8000_8000.
- R2: The pairing code selects the operands, with accumulators indexed A=0, B=1, C=2, D=3. The codes are: 0 = A1·A0, 1 = A1·B0, 2 = A1·C0, 3 = A1·D0, 4 = B1·C0, 5 = B1·D0, 6 = C1·C0, 7 = C1·D0. Here "1" is the upper word (acc_hi_i[k]) and "0" is the lower word (acc_lo_i[k]).
- R3: y_we_o is high for exactly the one cycle after each clock edge at which issue_i is sampled high. Y carries the new product in that same cycle.
- R4: While issue_i is low, y_o holds its value even when the accumulator words or the pairing code change.
- R5: sat_mode_i has no effect on y_o.
- R6: During and right after reset, y_o is 0 and y_we_o is 0.
- R7: A zero in either operand gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Starts one multiply this cycle |
| pair_sel_i | input | 3 | Operand pairing code (R2) |
| sat_mode_i | input | 1 | Saturation mode bit, ignored |
| acc_hi_i | input | 4×16 | Upper words of accumulators A..D |
| acc_lo_i | input | 4×16 | Lower words of accumulators A..D |
| y_o | output | 32 | Y register contents |
| y_we_o | output | 1 | Y write strobe |

## Verification
The bench uses the default 16-bit operand width and four accumulators. At these values all eight pairing codes can be driven directly. The sign-boundary operands 0x8000, 0x7FFF and 0xFFFF, and the zero operands, can each be placed in a chosen source slot while every other accumulator word carries a distractor value. A wrong selection or a wrong sign extension therefore shows up as a wrong Y value. Random operand and code pairs, checked against a wide-integer product, cover the rest of the operand space.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  localparam int unsigned DW    = 16;
  localparam int unsigned PW    = 2 * DW;
  localparam int unsigned NACC  = 4;
  localparam int unsigned IDXW  = $clog2(NACC);
  localparam int unsigned SELW  = 3;

  typedef struct packed {
    logic [IDXW-1:0] src_hi;
    logic [IDXW-1:0] src_lo;
  } pair_t;

  // Pairing code to accumulator indices
  function automatic pair_t decode_pair(input logic [SELW-1:0] sel);
    pair_t p;
    if (!sel[2]) begin
      p.src_hi = IDXW'(0);
      p.src_lo = sel[1:0];
    end else begin
      p.src_hi = sel[1] ? IDXW'(2) : IDXW'(1);
      p.src_lo = {1'b1, sel[0]};
    end
    return p;
  endfunction

  // Signed times unsigned, integer result
  function automatic logic [PW-1:0] mixed_mul(input logic [DW-1:0] s,
                                              input logic [DW-1:0] u);
    logic signed [PW:0] sx;
    logic signed [PW:0] ux;
    logic signed [PW:0] full;
    sx   = {{(PW+1-DW){s[DW-1]}}, s};
    ux   = {{(PW+1-DW){1'b0}}, u};
    full = sx * ux;
    return full[PW-1:0];
  endfunction
endpackage

// File: rtl/mixmul_opsel.sv
module mixmul_opsel
  import mixmul_pkg::*;
(
  input  logic [SELW-1:0]           pair_sel_i,
  input  logic [NACC-1:0][DW-1:0]   acc_hi_i,
  input  logic [NACC-1:0][DW-1:0]   acc_lo_i,
  output logic [DW-1:0]             op_s_o,
  output logic [DW-1:0]             op_u_o
);
  pair_t pair;

  always_comb begin
    pair   = decode_pair(pair_sel_i);
    op_s_o = acc_hi_i[pair.src_hi];
    op_u_o = acc_lo_i[pair.src_lo];
  end
endmodule

// File: rtl/mixmul_core.sv
module mixmul_core
  import mixmul_pkg::*;
(
  input  logic [DW-1:0] op_s_i,
  input  logic [DW-1:0] op_u_i,
  output logic [PW-1:0] prod_o
);
  always_comb prod_o = mixed_mul(op_s_i, op_u_i);
endmodule

// File: rtl/mixmul_wb.sv
module mixmul_wb
  import mixmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [PW-1:0] prod_i,
  output logic [PW-1:0] y_o,
  output logic          y_we_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_o    <= '0;
      y_we_o <= 1'b0;
    end else begin
      y_we_o <= issue_i;
      if (issue_i) y_o <= prod_i;
    end
  end

  // R3
  we_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> y_we_o);
  // R3
  we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !y_we_o);
  // R4
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(y_o));
endmodule

// File: rtl/mixmul_unit.sv
module mixmul_unit
  import mixmul_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_i,
  input  logic [SELW-1:0]           pair_sel_i,
  input  logic                      sat_mode_i,
  input  logic [NACC-1:0][DW-1:0]   acc_hi_i,
  input  logic [NACC-1:0][DW-1:0]   acc_lo_i,
  output logic [PW-1:0]             y_o,
  output logic                      y_we_o
);
  logic [DW-1:0] op_s;
  logic [DW-1:0] op_u;
  logic [PW-1:0] prod;
  logic          sat_unused;

  // Saturation mode is accepted but deliberately not used
  assign sat_unused = sat_mode_i;

  mixmul_opsel u_opsel (
    .pair_sel_i (pair_sel_i),
    .acc_hi_i   (acc_hi_i),
    .acc_lo_i   (acc_lo_i),
    .op_s_o     (op_s),
    .op_u_o     (op_u)
  );

  mixmul_core u_core (
    .op_s_i (op_s),
    .op_u_i (op_u),
    .prod_o (prod)
  );

  mixmul_wb u_wb (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue_i),
    .prod_i  (prod),
    .y_o     (y_o),
    .y_we_o  (y_we_o)
  );

  // R1
  prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_u != '0) |-> (prod[PW-1] == op_s[DW-1]));
  // R7
  prod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_s == '0 || op_u == '0) |-> (prod == '0));
  // R3
  y_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (y_o == $past(prod)));
endmodule

// File: tb/mixmul_unit_tb.sv
module mixmul_unit_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue_i = 1'b0;
  logic [2:0]        pair_sel_i = '0;
  logic              sat_mode_i = 1'b0;
  logic [3:0][15:0]  acc_hi_i = '0;
  logic [3:0][15:0]  acc_lo_i = '0;
  logic [31:0]       y_o;
  logic              y_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mixmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .pair_sel_i(pair_sel_i),
    .sat_mode_i(sat_mode_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
    .y_o(y_o), .y_we_o(y_we_o)
  );

  // {signed operand, unsigned operand, expected Y}
  localparam logic [63:0] VEC [8] = '{
    {16'hFFFE, 16'h0002, 32'hFFFF_FFFC},
    {16'h8000, 16'hFFFF, 32'h8000_8000},
    {16'h7FFF, 16'hFFFF, 32'h7FFE_8001},
    {16'h0000, 16'hFFFF, 32'h0000_0000},
    {16'hFFFF, 16'hFFFF, 32'hFFFF_0001},
    {16'h0001, 16'hFFFF, 32'h0000_FFFF},
    {16'h8000, 16'h0001, 32'hFFFF_8000},
    {16'h1234, 16'h0000, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench view of the pairing table (R2)
  task automatic place(input logic [2:0] sel, input logic [15:0] a,
                       input logic [15:0] b);
    int hi_idx;
    int lo_idx;
    case (sel)
      3'd0: begin hi_idx = 0; lo_idx = 0; end
      3'd1: begin hi_idx = 0; lo_idx = 1; end
      3'd2: begin hi_idx = 0; lo_idx = 2; end
      3'd3: begin hi_idx = 0; lo_idx = 3; end
      3'd4: begin hi_idx = 1; lo_idx = 2; end
      3'd5: begin hi_idx = 1; lo_idx = 3; end
      3'd6: begin hi_idx = 2; lo_idx = 2; end
      default: begin hi_idx = 2; lo_idx = 3; end
    endcase
    for (int k = 0; k < 4; k++) begin
      acc_hi_i[k] = 16'h5A5A + 16'(k);
      acc_lo_i[k] = 16'h0C3C + 16'(k);
    end
    acc_hi_i[hi_idx] = a;
    acc_lo_i[lo_idx] = b;
    pair_sel_i = sel;
  endtask

  function automatic logic [31:0] ref_mul(input logic [15:0] a,
                                          input logic [15:0] b);
    longint r;
    r = longint'($signed(a)) * longint'(b);
    return r[31:0];
  endfunction

  // Issue one operation and sample on the following falling edge
  task automatic run_op(input logic [2:0] sel, input logic [15:0] a,
                        input logic [15:0] b, input bit sat,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    place(sel, a, b);
    sat_mode_i = sat;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    check(y_o == exp, req, y_o, exp);
    check(y_we_o == 1'b1, "R3", {31'b0, y_we_o}, 32'd1);
  endtask

  initial begin
    logic [31:0] held;
    // R6 reset state
    #1;
    check(y_o == 32'd0, "R6", y_o, 32'd0);
    check(y_we_o == 1'b0, "R6", {31'b0, y_we_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(y_o == 32'd0 && y_we_o == 1'b0, "R6", y_o, 32'd0);

    // R1 R2 R7: table walk, vector i on pairing code i
    for (int i = 0; i < 8; i++) begin
      run_op(3'(i), VEC[i][63:48], VEC[i][47:32], 1'b0, VEC[i][31:0],
             (VEC[i][31:0] == 0) ? "R7" : "R1/R2");
    end

    // R3 strobe drops, R4 Y holds while inputs change
    run_op(3'd5, 16'h8000, 16'hFFFF, 1'b0, 32'h8000_8000, "R1");
    held = y_o;
    place(3'd2, 16'h7FFF, 16'h1111);
    @(negedge clk);
    check(y_we_o == 1'b0, "R3", {31'b0, y_we_o}, 32'd0);
    check(y_o == held, "R4", y_o, held);
    pair_sel_i = 3'd7;
    acc_hi_i = '1;
    @(negedge clk);
    check(y_o == held, "R4", y_o, held);

    // R5 saturation mode on, extreme products stay unlimited
    run_op(3'd0, 16'h8000, 16'hFFFF, 1'b1, 32'h8000_8000, "R5");
    run_op(3'd6, 16'h7FFF, 16'hFFFF, 1'b1, 32'h7FFE_8001, "R5");

    // R7 zero signed operand with unsigned max
    run_op(3'd4, 16'h0000, 16'hFFFF, 1'b0, 32'd0, "R7");

    // Back-to-back issues: strobe stays high, Y follows each
    @(negedge clk);
    place(3'd3, 16'hFFFE, 16'h0002);
    issue_i = 1'b1;
    @(negedge clk);
    check(y_o == 32'hFFFF_FFFC, "R3", y_o, 32'hFFFF_FFFC);
    place(3'd1, 16'h0003, 16'h0004);
    @(negedge clk);
    issue_i = 1'b0;
    check(y_o == 32'h0000_000C && y_we_o, "R3", y_o, 32'h0000_000C);

    // R1 R2 random vectors
    for (int j = 0; j < 40; j++) begin
      logic [15:0] a;
      logic [15:0] b;
      logic [2:0]  s;
      a = 16'($urandom);
      b = 16'($urandom);
      s = 3'($urandom);
      run_op(s, a, b, 1'($urandom), ref_mul(a, b), "R1/R2");
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule